// File: doc/BRIEF.md
# Five-Master Round-Robin Bus Arbiter

This block decides which of five bus masters owns a shared AHB-style bus. Each master has a request line and a lock line. The arbiter also sees the shared ready signal and a two-bit burst-type code that comes with the winning request. From these it drives one grant per master, the binary index of the current owner, a flag that mirrors the owner's request, a master-lock flag, and a start strobe that opens each new transfer sequence.

A new sequence starts only when four conditions hold. The bus must be idle, meaning no fixed-length beats remain, no open-ended burst is running and no locked sequence is held. Ready must be high in both the current and the previous cycle. At least one master must request. The winner is picked round-robin, with the search beginning at the master after the current owner. The grant moves to the owner register on a ready-high clock edge. With no request pending, the bus parks on master 0. A fixed four-beat burst is counted down on ready-high cycles. An open-ended burst and a locked sequence both last until the owner drops its request in a ready-high cycle.

Top module: `bus_arbiter_rr`

## Requirements
- R1: After reset the owner index is 0, master 0 holds the grant, and start and master-lock are low. The owner index never leaves the range 0 to 4.
- R2: own_req_o equals the request bit of the master named by owner_o in every cycle.
- R3: start_o is low in any cycle that follows a cycle in which ready_i was low.
- R4: start_o is high exactly when all of these hold: no sequence is in flight, ready_i is high now, ready_i was high in the previous cycle, and at least one request is high.
- R5: A start with burst code 2'b01 loads a beat count of 4. The count drops by one on each ready-high cycle. While it is non-zero, start stays low and the grant stays on the owner.
- R6: A start with burst code 2'b10 or 2'b11 opens an open-ended burst. That burst holds the bus until a ready-high cycle in which the owner's request is low. A start with code 2'b00 leaves the bus free from the next cycle.
- R7: When the bus is free and start is permitted, the grant goes to the first requesting master found by searching owner+1, owner+2, and so on, modulo 5, with the owner itself checked last. When the bus is free and no master requests, master 0 is granted.
- R8: On a clock edge with ready_i high, owner_o takes the index of the granted master. On an edge with ready_i low, owner_o is unchanged.
- R9: Exactly one grant is active in every cycle. grant0_n_o is active-low, and grant_o bit k is the active-high grant for master k (k = 1..4).
- R10: If the winner's lock line is high at a start, mlock_o goes high from the next cycle. Further starts are then blocked until a ready-high cycle in which the owner's request is low, and mlock_o goes low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Request line of each master |
| lock_i | input | 5 | Lock line of each master, only raised together with its request |
| ready_i | input | 1 | Shared transfer-ready signal |
| burst_i | input | 2 | Burst code of the starting sequence: 00 single, 01 four beats, 1x open-ended |
| grant0_n_o | output | 1 | Grant of master 0, active low |
| grant_o | output | 4 | Grants of masters 1 to 4 (bit k for master k), active high |
| owner_o | output | 3 | Binary index of the current bus owner |
| own_req_o | output | 1 | Request line of the current owner |
| mlock_o | output | 1 | A locked sequence is in progress |
| start_o | output | 1 | Opens a new transfer sequence in this cycle |

## Verification
The hardest situation to reach from the ports is a locked open-ended burst that ends in a cycle where ready has just come back after a stall, while other masters are still waiting. Only that combination shows whether the lock release, the ready-history gate on start and the round-robin pointer interact correctly. Directed sequences build this case and similar ones on purpose: four-beat bursts with ready stalls in the middle, a request that is held through a low-ready cycle, and a lock that is released while a competitor waits. A long random phase with sticky request lines follows. In that phase, lock lines are only raised under a request, and ready is low about a quarter of the time, so the same corners recur in many orders. A bench model checks every output in every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      BURST_SINGLE = 2'b00,
      BURST_FOUR   = 2'b01,
      BURST_OPEN   = 2'b10,
      BURST_OPEN_B = 2'b11
   } burst_e;

   function automatic logic burst_is_open(input burst_e b);
      return b[1];
   endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int N_MASTERS = 5,
   parameter int IDX_W     = $clog2(N_MASTERS)
) (
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [IDX_W-1:0]     last_i,
   output logic                 any_o,
   output logic [IDX_W-1:0]     win_o
);

   if (N_MASTERS < 2) begin : g_bad_count
      $error("arb_rr_pick needs at least two masters");
   end

   always_comb begin
      logic found;
      found = 1'b0;
      win_o = '0;
      for (int k = 1; k <= N_MASTERS; k++) begin
         int idx;
         idx = (int'(last_i) + k) % N_MASTERS;
         if (!found && req_i[idx]) begin
            win_o = IDX_W'(idx);
            found = 1'b1;
         end
      end
   end

   assign any_o = |req_i;

endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
   import arb_pkg::*;
#(
   parameter int FIXED_BEATS = 4,
   parameter int CNT_W       = $clog2(FIXED_BEATS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready_i,
   input  logic       start_i,
   input  logic [1:0] burst_i,
   input  logic       lock_win_i,
   input  logic       own_req_i,
   output logic       busy_o,
   output logic       lock_o
);

   if (FIXED_BEATS < 1 || FIXED_BEATS >= 2**CNT_W) begin : g_bad_beats
      $error("arb_burst_track: beat count does not fit its counter");
   end

   burst_e           kind;
   logic [CNT_W-1:0] beats_q;
   logic             open_q;
   logic             lock_q;
   logic             release_ok;

   assign kind       = burst_e'(burst_i);
   assign release_ok = ready_i && !own_req_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beats_q <= '0;
         open_q  <= 1'b0;
         lock_q  <= 1'b0;
      end else begin
         if (start_i && kind == BURST_FOUR)
            beats_q <= CNT_W'(FIXED_BEATS);
         else if (ready_i && beats_q != '0)
            beats_q <= beats_q - 1'b1;

         if (start_i && burst_is_open(kind))
            open_q <= 1'b1;
         else if (open_q && release_ok)
            open_q <= 1'b0;

         if (start_i && lock_win_i)
            lock_q <= 1'b1;
         else if (lock_q && release_ok)
            lock_q <= 1'b0;
      end
   end

   assign busy_o = (beats_q != '0) || open_q || lock_q;
   assign lock_o = lock_q;

   assert_beats_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      beats_q <= CNT_W'(FIXED_BEATS));

   assert_beats_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beats_q != '0 && ready_i) |=> beats_q == $past(beats_q) - 1'b1);

   assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> beats_q == '0 && !open_q && !lock_q);

   assert_lock_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(start_i) && $past(lock_win_i));

endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec #(
   parameter int                 N_MASTERS    = 5,
   parameter int                 IDX_W        = $clog2(N_MASTERS),
   parameter logic [N_MASTERS-1:0] ACT_LOW_MASK = '0
) (
   input  logic [IDX_W-1:0]     sel_i,
   output logic [N_MASTERS-1:0] lvl_o
);

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_line
      if (ACT_LOW_MASK[g]) begin : g_low
         assign lvl_o[g] = (sel_i != IDX_W'(g));
      end else begin : g_high
         assign lvl_o[g] = (sel_i == IDX_W'(g));
      end
   end

endmodule

// File: rtl/bus_arbiter_rr.sv
module bus_arbiter_rr #(
   parameter  int N_MASTERS   = 5,
   parameter  int FIXED_BEATS = 4,
   localparam int IDX_W       = $clog2(N_MASTERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] lock_i,
   input  logic                 ready_i,
   input  logic [1:0]           burst_i,
   output logic                 grant0_n_o,
   output logic [N_MASTERS-1:1] grant_o,
   output logic [IDX_W-1:0]     owner_o,
   output logic                 own_req_o,
   output logic                 mlock_o,
   output logic                 start_o
);

   localparam logic [N_MASTERS-1:0] LOW_MASK = N_MASTERS'(1);

   if (N_MASTERS > 2**IDX_W || N_MASTERS < 2) begin : g_bad_masters
      $error("bus_arbiter_rr: master count out of range");
   end

   logic [IDX_W-1:0]     owner_q;
   logic                 ready_q;
   logic                 any_req;
   logic [IDX_W-1:0]     win_idx;
   logic [IDX_W-1:0]     grant_idx;
   logic                 busy;
   logic                 start_ok;
   logic [N_MASTERS-1:0] grant_lvl;

   arb_rr_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
      .req_i  (req_i),
      .last_i (owner_q),
      .any_o  (any_req),
      .win_o  (win_idx)
   );

   assign start_ok = ready_q && ready_i;
   assign start_o  = !busy && any_req && start_ok;

   always_comb begin
      if (busy)          grant_idx = owner_q;
      else if (!any_req) grant_idx = '0;
      else if (start_ok) grant_idx = win_idx;
      else               grant_idx = owner_q;
   end

   arb_burst_track #(.FIXED_BEATS(FIXED_BEATS)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_i    (ready_i),
      .start_i    (start_o),
      .burst_i    (burst_i),
      .lock_win_i (lock_i[win_idx]),
      .own_req_i  (req_i[owner_q]),
      .busy_o     (busy),
      .lock_o     (mlock_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= ready_i;
         if (ready_i) owner_q <= grant_idx;
      end
   end

   arb_grant_dec #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W), .ACT_LOW_MASK(LOW_MASK)) u_dec (
      .sel_i (grant_idx),
      .lvl_o (grant_lvl)
   );

   assign grant0_n_o = grant_lvl[0];
   assign grant_o    = grant_lvl[N_MASTERS-1:1];
   assign owner_o    = owner_q;
   assign own_req_o  = req_i[owner_q];

   assert_owner_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      owner_q < IDX_W'(N_MASTERS));

   assert_start_prev_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(ready_i));

   assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> grant_idx == owner_q);

   assert_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready_i |=> owner_q == $past(grant_idx));

   assert_owner_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_i |=> $stable(owner_q));

   assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({grant_o, ~grant0_n_o}));

endmodule

// File: tb/bus_arbiter_rr_tb_top.sv
module bus_arbiter_rr_tb_top;

   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] lck = '0;
   logic         rdy = 1'b0;
   logic [1:0]   bst = 2'b00;
   logic         grant0_n;
   logic [N-1:1] grant;
   logic [2:0]   owner;
   logic         own_req;
   logic         mlock;
   logic         start;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   int m_owner = 0, m_beats = 0;
   bit m_open = 0, m_lock = 0, m_rq = 0;

   always #4 clk = ~clk;

   bus_arbiter_rr dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lck), .ready_i(rdy),
      .burst_i(bst), .grant0_n_o(grant0_n), .grant_o(grant), .owner_o(owner),
      .own_req_o(own_req), .mlock_o(mlock), .start_o(start)
   );

   function automatic int rr_pick(logic [N-1:0] r, int last);
      for (int k = 1; k <= N; k++) begin
         int idx = (last + k) % N;
         if (r[idx]) return idx;
      end
      return 0;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(logic [N-1:0] r, logic [N-1:0] l, logic rd, logic [1:0] b);
      bit busy, any, st_ok, e_start;
      int win, gidx;
      logic [N-1:0] gvec;
      string stag;
      req = r; lck = l & r; rdy = rd; bst = b;
      busy  = (m_beats != 0) || m_open || m_lock;
      any   = |r;
      st_ok = m_rq && rd;
      win   = rr_pick(r, m_owner);
      e_start = !busy && any && st_ok;
      if (busy)        gidx = m_owner;
      else if (!any)   gidx = 0;
      else if (st_ok)  gidx = win;
      else             gidx = m_owner;
      #2;
      gvec = {grant, ~grant0_n};
      stag = (m_beats != 0) ? "R5" : (m_open ? "R6" : (m_lock ? "R10" : "R4"));
      chk(stag, "start", start, e_start);
      chk("R7", "grant", gvec, 1 << gidx);
      chk("R9", "grant_count", $countones(gvec), 1);
      chk("R8", "owner", owner, m_owner);
      chk("R2", "own_req", own_req, r[m_owner]);
      chk("R10", "mlock", mlock, m_lock);
      if (!m_rq) chk("R3", "start_after_low_ready", start, 0);
      @(posedge clk);
      if (e_start && b == 2'b01) m_beats = 4;
      else if (rd && m_beats != 0) m_beats--;
      if (e_start && b[1]) m_open = 1;
      else if (m_open && rd && !r[m_owner]) m_open = 0;
      if (e_start && lck[win]) m_lock = 1;
      else if (m_lock && rd && !r[m_owner]) m_lock = 0;
      if (rd) m_owner = gidx;
      m_rq = rd;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] rr, ll;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1", "reset_owner", owner, 0);
      chk("R1", "reset_grant0_n", grant0_n, 0);
      chk("R1", "reset_start", start, 0);
      chk("R1", "reset_mlock", mlock, 0);
      rst_n = 1'b1;

      // idle parking on master 0 (R7)
      repeat (3) step('0, '0, 1, 2'b00);
      // ready low then request from master 3: no start after low ready (R3)
      step('0, '0, 0, 2'b00);
      step(5'b01000, '0, 1, 2'b00);
      step(5'b01000, '0, 1, 2'b00);
      step('0, '0, 1, 2'b00);
      // four-beat burst by master 1 with stalls while master 2 waits (R5)
      step(5'b00010, '0, 1, 2'b01);
      step(5'b00110, '0, 1, 2'b00);
      step(5'b00110, '0, 0, 2'b00);
      repeat (5) step(5'b00110, '0, 1, 2'b00);
      // open-ended burst by master 4 until it drops (R6)
      step(5'b10000, '0, 1, 2'b10);
      repeat (3) step(5'b10001, '0, 1, 2'b00);
      step(5'b00001, '0, 0, 2'b00);
      step(5'b00001, '0, 1, 2'b00);
      repeat (2) step(5'b00001, '0, 1, 2'b00);
      // locked sequence by master 2, released after ready stall (R10)
      step('0, '0, 1, 2'b00);
      step(5'b00100, 5'b00100, 1, 2'b00);
      repeat (3) step(5'b01100, 5'b00100, 1, 2'b00);
      step(5'b01000, '0, 0, 2'b00);
      step(5'b01000, '0, 1, 2'b11);
      repeat (3) step(5'b01010, '0, 1, 2'b00);

      // random phase
      rr = '0; ll = '0;
      for (int c = 0; c < 4000; c++) begin
         for (int m = 0; m < N; m++) begin
            if ($urandom % 5 == 0) rr[m] = ~rr[m];
            if ($urandom % 3 == 0) ll[m] = ($urandom % 4 == 0);
         end
         step(rr, ll & rr, ($urandom % 4) != 0, 2'($urandom));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule